// File: doc/BRIEF.md
# Coherent Cache Request Sequencer

This block steers one upstream command at a time through a small direct-mapped cache that fronts a coherent host link. A command is a write (three flavours), a read (two flavours) or a fence, each with a line address and a request tag. The sequencer looks up the single slot the address maps to and compares the stored tag and line state (invalid, shared or modified). It then drives between zero and three ordered link cycles, updates the slot and emits one typed response that echoes the request tag.

A write may take three phases. A conflicting victim is removed first. Ownership is then gained and the write response is sent. Some write flavours then add a trailing writeback that leaves the slot invalid. Reads either hit and answer at once, or fetch the line with a cycle whose kind decides whether the line is kept. The link side is a stub handshake: each cycle is offered with valid/ready and an opcode, and the next phase waits for a separate completion pulse. Data payloads are not stored here.

Top module: `coh_req_seq`

## Requirements
- R1: Command codes on `req_cmd` are 0 write-invalidate, 1 write-modified, 2 write-push, 3 shared-read, 4 invalidate-read and 5 fence. Each accepted command yields exactly one `rsp_valid` pulse whose `rsp_tag` equals its request tag. `rsp_kind` is 1 for writes, 2 for reads and 3 for fences, and `rsp_has_data` is 1 only for reads.
- R2: A write whose address hits a line in the modified state drives no link cycle before it responds, and the line stays modified.
- R3: A write whose slot is shared with the same tag, or invalid, first drives a get-exclusive cycle (opcode 1) at its own address. The line becomes modified, and the response follows that cycle's completion.
- R4: After responding, a write-invalidate drives a modified writeback (opcode 2) and a write-push drives a push writeback (opcode 3), both at the write address, and the line becomes invalid. A write-modified adds no cycle and keeps the line modified.
- R5: When the slot holds a valid line with a different tag, that victim is removed first at its own address: a modified victim with opcode 2, a shared victim with a clean drop (opcode 4). The slot becomes invalid and the command's normal flow follows.
- R6: A read that hits a shared or modified line drives no link cycle and leaves the line state unchanged.
- R7: On a read miss, a shared-read drives a shared fetch (opcode 5) and installs the line shared. An invalidate-read drives a one-time fetch (opcode 6) and leaves the slot invalid.
- R8: A fence drives no link cycle and changes no line. Its response comes only after every earlier write has completed all of its phases, including any trailing writeback.
- R9: A link cycle holds `link_valid`, `link_op` and `link_addr` steady until `link_ready`. The following phase starts only after `link_done` arrives.
- R10: `req_ready` is high only when the sequencer is idle. It stays low from acceptance until the last phase of the command ends.
- R11: The low log2(LINES) address bits select the slot and the remaining bits form the stored tag. The state code is 2'b00 invalid, 2'b01 shared and 2'b11 modified, and every slot is invalid after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream command present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_cmd | input | 3 | Command code |
| req_addr | input | ADDR_W | Line address |
| req_tag | input | RTAG_W | Request tag, echoed in the response |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_kind | output | 2 | 1 write, 2 read, 3 fence |
| rsp_has_data | output | 1 | Response carries read data |
| rsp_tag | output | RTAG_W | Echoed request tag |
| link_valid | output | 1 | Link cycle offered |
| link_ready | input | 1 | Link accepts the offered cycle |
| link_op | output | 3 | Link cycle opcode |
| link_addr | output | ADDR_W | Line address of the link cycle |
| link_done | input | 1 | Completion of the accepted link cycle |

## Verification
The assertions assume that the link side pulses `link_done` only after it has accepted a cycle and before it accepts another one, so each completion belongs to exactly one phase. They also assume that `req_cmd` uses only codes 0 to 5. The bench models the host with a single process that stalls one cycle, grants `link_ready` for one cycle and pulses `link_done` two cycles later, never overlapping cycles. Its request task holds the command fields steady until the sequencer takes them.

// File: rtl/coh_req_seq_pkg.sv
package coh_req_seq_pkg;

  typedef enum logic [2:0] {
    CMD_WR_INV  = 3'd0,
    CMD_WR_MOD  = 3'd1,
    CMD_WR_PUSH = 3'd2,
    CMD_RD_SHR  = 3'd3,
    CMD_RD_INV  = 3'd4,
    CMD_FENCE   = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    LOP_NONE       = 3'd0,
    LOP_GET_EXCL   = 3'd1,
    LOP_WB_INV     = 3'd2,
    LOP_WB_PUSH    = 3'd3,
    LOP_DROP_CLEAN = 3'd4,
    LOP_RD_SHARED  = 3'd5,
    LOP_RD_ONCE    = 3'd6
  } lop_e;

  typedef enum logic [1:0] {
    LS_I = 2'b00,
    LS_S = 2'b01,
    LS_M = 2'b11
  } lstate_e;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_WRITE = 2'd1,
    RSP_READ  = 2'd2,
    RSP_FENCE = 2'd3
  } rsp_e;

  typedef enum logic [1:0] {
    PH_VICTIM,
    PH_OWN,
    PH_FILL,
    PH_TAIL
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_LREQ,
    ST_LWAIT
  } fsm_e;

  function automatic logic is_write(input logic [2:0] c);
    return (c == CMD_WR_INV) || (c == CMD_WR_MOD) || (c == CMD_WR_PUSH);
  endfunction

  function automatic logic is_read(input logic [2:0] c);
    return (c == CMD_RD_SHR) || (c == CMD_RD_INV);
  endfunction

  function automatic rsp_e rsp_of(input logic [2:0] c);
    if (is_write(c)) return RSP_WRITE;
    if (is_read(c))  return RSP_READ;
    return RSP_FENCE;
  endfunction

  function automatic lop_e tail_op(input logic [2:0] c);
    case (c)
      CMD_WR_INV:  return LOP_WB_INV;
      CMD_WR_PUSH: return LOP_WB_PUSH;
      default:     return LOP_NONE;
    endcase
  endfunction

  function automatic lop_e victim_op(input logic [1:0] s);
    return (s == LS_M) ? LOP_WB_INV : LOP_DROP_CLEAN;
  endfunction

  function automatic lop_e fill_op(input logic [2:0] c);
    return (c == CMD_RD_SHR) ? LOP_RD_SHARED : LOP_RD_ONCE;
  endfunction

  function automatic lstate_e fill_state(input logic [2:0] c);
    return (c == CMD_RD_SHR) ? LS_S : LS_I;
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_req_seq_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int LTAG_W = 5,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [1:0]        rd_state,
  output logic [LTAG_W-1:0] rd_tag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_state,
  input  logic [LTAG_W-1:0] wr_tag
);

  logic [1:0]        st_q  [LINES];
  logic [LTAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel_w;
    assign sel_w = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]  <= LS_I;
        tag_q[g] <= '0;
      end else if (sel_w) begin
        st_q[g]  <= wr_state;
        tag_q[g] <= wr_tag;
      end
    end
  end

  assign rd_state = st_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  // R11: only the three legal state codes are ever stored
  p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_state != 2'b10));

  // R11: a stored line reads back as written on the next cycle
  p_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) ##1 (rd_idx == $past(wr_idx))
      |-> (rd_state == $past(wr_state)) && (rd_tag == $past(wr_tag)));

endmodule

// File: rtl/coh_phase_ctl.sv
module coh_phase_ctl
  import coh_req_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 8,
  parameter int RTAG_W = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int LTAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [RTAG_W-1:0] req_tag,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic              rsp_has_data,
  output logic [RTAG_W-1:0] rsp_tag,
  output logic              link_valid,
  input  logic              link_ready,
  output logic [2:0]        link_op,
  output logic [ADDR_W-1:0] link_addr,
  input  logic              link_done,
  output logic [IDX_W-1:0]  arr_idx,
  input  logic [1:0]        arr_rd_state,
  input  logic [LTAG_W-1:0] arr_rd_tag,
  output logic              arr_we,
  output logic [1:0]        arr_wr_state,
  output logic [LTAG_W-1:0] arr_wr_tag
);

  fsm_e              fsm_q, fsm_d;
  logic [2:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [RTAG_W-1:0] rtag_q;
  phase_e            phase_q, phase_d;
  lop_e              lop_q, lop_d;
  logic [ADDR_W-1:0] laddr_q, laddr_d;
  logic              rsp_valid_q;
  logic [1:0]        rsp_kind_q;
  logic              rsp_data_q;
  logic [RTAG_W-1:0] rsp_tag_q;

  // named internal events
  logic              ev_accept, ev_hit, ev_conflict, ev_link_fire, ev_link_done;
  logic              ev_start_link, ev_rsp;
  logic [LTAG_W-1:0] my_tag;
  logic              line_live;

  assign arr_idx      = addr_q[IDX_W-1:0];
  assign my_tag       = addr_q[ADDR_W-1:IDX_W];
  assign line_live    = (arr_rd_state != LS_I);
  assign ev_hit       = line_live && (arr_rd_tag == my_tag);
  assign ev_conflict  = line_live && (arr_rd_tag != my_tag);
  assign req_ready    = (fsm_q == ST_IDLE);
  assign ev_accept    = req_valid && req_ready;
  assign link_valid   = (fsm_q == ST_LREQ);
  assign ev_link_fire = link_valid && link_ready;
  assign ev_link_done = (fsm_q == ST_LWAIT) && link_done;

  always_comb begin
    fsm_d         = fsm_q;
    phase_d       = phase_q;
    lop_d         = lop_q;
    laddr_d       = laddr_q;
    ev_start_link = 1'b0;
    ev_rsp        = 1'b0;
    arr_we        = 1'b0;
    arr_wr_state  = LS_I;
    arr_wr_tag    = my_tag;
    case (fsm_q)
      ST_IDLE: if (req_valid) fsm_d = ST_DECIDE;
      ST_DECIDE: begin
        if (!is_write(cmd_q) && !is_read(cmd_q)) begin
          ev_rsp = 1'b1;
          fsm_d  = ST_IDLE;
        end else if (ev_conflict) begin
          ev_start_link = 1'b1;
          lop_d   = victim_op(arr_rd_state);
          laddr_d = {arr_rd_tag, arr_idx};
          phase_d = PH_VICTIM;
        end else if (is_write(cmd_q)) begin
          if (ev_hit && arr_rd_state == LS_M) begin
            ev_rsp = 1'b1;
            if (tail_op(cmd_q) != LOP_NONE) begin
              ev_start_link = 1'b1;
              lop_d   = tail_op(cmd_q);
              laddr_d = addr_q;
              phase_d = PH_TAIL;
            end else begin
              fsm_d = ST_IDLE;
            end
          end else begin
            ev_start_link = 1'b1;
            lop_d   = LOP_GET_EXCL;
            laddr_d = addr_q;
            phase_d = PH_OWN;
          end
        end else if (ev_hit) begin
          ev_rsp = 1'b1;
          fsm_d  = ST_IDLE;
        end else begin
          ev_start_link = 1'b1;
          lop_d   = fill_op(cmd_q);
          laddr_d = addr_q;
          phase_d = PH_FILL;
        end
      end
      ST_LREQ: if (link_ready) fsm_d = ST_LWAIT;
      ST_LWAIT: if (link_done) begin
        arr_we = 1'b1;
        case (phase_q)
          PH_VICTIM: begin
            arr_wr_state = LS_I;
            arr_wr_tag   = arr_rd_tag;
            fsm_d        = ST_DECIDE;
          end
          PH_OWN: begin
            arr_wr_state = LS_M;
            ev_rsp       = 1'b1;
            if (tail_op(cmd_q) != LOP_NONE) begin
              ev_start_link = 1'b1;
              lop_d   = tail_op(cmd_q);
              laddr_d = addr_q;
              phase_d = PH_TAIL;
            end else begin
              fsm_d = ST_IDLE;
            end
          end
          PH_FILL: begin
            arr_wr_state = fill_state(cmd_q);
            ev_rsp       = 1'b1;
            fsm_d        = ST_IDLE;
          end
          default: begin
            arr_wr_state = LS_I;
            fsm_d        = ST_IDLE;
          end
        endcase
      end
      default: fsm_d = ST_IDLE;
    endcase
    if (ev_start_link) fsm_d = ST_LREQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q       <= ST_IDLE;
      cmd_q       <= CMD_FENCE;
      addr_q      <= '0;
      rtag_q      <= '0;
      phase_q     <= PH_VICTIM;
      lop_q       <= LOP_NONE;
      laddr_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= RSP_NONE;
      rsp_data_q  <= 1'b0;
      rsp_tag_q   <= '0;
    end else begin
      fsm_q   <= fsm_d;
      phase_q <= phase_d;
      lop_q   <= lop_d;
      laddr_q <= laddr_d;
      if (ev_accept) begin
        cmd_q  <= req_cmd;
        addr_q <= req_addr;
        rtag_q <= req_tag;
      end
      rsp_valid_q <= ev_rsp;
      if (ev_rsp) begin
        rsp_kind_q <= rsp_of(cmd_q);
        rsp_data_q <= is_read(cmd_q);
        rsp_tag_q  <= rtag_q;
      end
    end
  end

  assign link_op      = lop_q;
  assign link_addr    = laddr_q;
  assign rsp_valid    = rsp_valid_q;
  assign rsp_kind     = rsp_kind_q;
  assign rsp_has_data = rsp_data_q;
  assign rsp_tag      = rsp_tag_q;

  // R9: an offered link cycle stays put until it is taken
  p_link_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid && !link_ready |=> link_valid && $stable(link_op) && $stable(link_addr));

  // R9: after a link cycle is taken, no new one is offered in the next cycle
  p_wait_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link_fire |=> !link_valid);

  // R10: nothing is accepted in the cycle after an acceptance
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);

  // R8: a fence response never follows a link cycle offer
  p_fence_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == RSP_FENCE |-> !$past(link_valid) && !$past(arr_we));

  // R2: a write hitting a modified line answers in the next cycle
  p_hitm_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == ST_DECIDE && is_write(cmd_q) && ev_hit && arr_rd_state == LS_M) |=> rsp_valid);

  // R3: ownership always installs a modified line
  p_own_to_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link_done && phase_q == PH_OWN |-> arr_we && arr_wr_state == LS_M);

endmodule

// File: rtl/coh_req_seq.sv
module coh_req_seq
  import coh_req_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 8,
  parameter int RTAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [RTAG_W-1:0] req_tag,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic              rsp_has_data,
  output logic [RTAG_W-1:0] rsp_tag,
  output logic              link_valid,
  input  logic              link_ready,
  output logic [2:0]        link_op,
  output logic [ADDR_W-1:0] link_addr,
  input  logic              link_done
);

  localparam int IDX_W  = $clog2(LINES);
  localparam int LTAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  arr_idx;
  logic [1:0]        arr_rd_state, arr_wr_state;
  logic [LTAG_W-1:0] arr_rd_tag, arr_wr_tag;
  logic              arr_we;

  coh_line_store #(.LINES(LINES), .LTAG_W(LTAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (arr_idx),
    .rd_state (arr_rd_state),
    .rd_tag   (arr_rd_tag),
    .wr_en    (arr_we),
    .wr_idx   (arr_idx),
    .wr_state (arr_wr_state),
    .wr_tag   (arr_wr_tag)
  );

  coh_phase_ctl #(.ADDR_W(ADDR_W), .LINES(LINES), .RTAG_W(RTAG_W)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_cmd      (req_cmd),
    .req_addr     (req_addr),
    .req_tag      (req_tag),
    .rsp_valid    (rsp_valid),
    .rsp_kind     (rsp_kind),
    .rsp_has_data (rsp_has_data),
    .rsp_tag      (rsp_tag),
    .link_valid   (link_valid),
    .link_ready   (link_ready),
    .link_op      (link_op),
    .link_addr    (link_addr),
    .link_done    (link_done),
    .arr_idx      (arr_idx),
    .arr_rd_state (arr_rd_state),
    .arr_rd_tag   (arr_rd_tag),
    .arr_we       (arr_we),
    .arr_wr_state (arr_wr_state),
    .arr_wr_tag   (arr_wr_tag)
  );

  // R1: data rides only on read responses
  p_data_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_has_data |-> rsp_kind == RSP_READ);

  // R10: the port never takes a command while a link cycle is offered
  p_ready_vs_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> !req_ready);

endmodule

// File: tb/coh_req_seq_tb.sv
`timescale 1ns/1ps
module coh_req_seq_tb;

  localparam int ADDR_W = 8;
  localparam int RTAG_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [2:0]        req_cmd = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [RTAG_W-1:0] req_tag = '0;
  logic              rsp_valid;
  logic [1:0]        rsp_kind;
  logic              rsp_has_data;
  logic [RTAG_W-1:0] rsp_tag;
  logic              link_valid;
  logic              link_ready = 1'b0;
  logic [2:0]        link_op;
  logic [ADDR_W-1:0] link_addr;
  logic              link_done = 1'b0;

  coh_req_seq #(.ADDR_W(ADDR_W), .LINES(8), .RTAG_W(RTAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_has_data(rsp_has_data),
    .rsp_tag(rsp_tag),
    .link_valid(link_valid), .link_ready(link_ready), .link_op(link_op),
    .link_addr(link_addr), .link_done(link_done)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int op_cnt = 0;
  int op_log [8];
  int ad_log [8];
  int rsp_cnt = 0;
  int rk_log [8];
  int rt_log [8];
  int rd_log [8];
  time rsp_t [8];
  time done_t = 0;
  int overlap = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // host model: one cycle stall, one-cycle ready, completion two cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (link_valid) begin
        @(negedge clk);
        link_ready = 1'b1;
        if (op_cnt < 8) begin
          op_log[op_cnt] = int'(link_op);
          ad_log[op_cnt] = int'(link_addr);
        end
        op_cnt++;
        @(negedge clk);
        link_ready = 1'b0;
        @(negedge clk);
        link_done = 1'b1;
        done_t = $time;
        @(negedge clk);
        link_done = 1'b0;
      end
    end
  end

  // response monitor
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && rsp_valid) begin
        if (rsp_cnt < 8) begin
          rk_log[rsp_cnt] = int'(rsp_kind);
          rt_log[rsp_cnt] = int'(rsp_tag);
          rd_log[rsp_cnt] = int'(rsp_has_data);
          rsp_t[rsp_cnt]  = $time;
        end
        rsp_cnt++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req_ready && link_valid) overlap++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  task automatic clear_logs();
    op_cnt = 0;
    rsp_cnt = 0;
  endtask

  task automatic send(input int cmd, input int addr, input int tag);
    req_cmd   = 3'(cmd);
    req_addr  = ADDR_W'(addr);
    req_tag   = RTAG_W'(tag);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(output int busy);
    busy = 0;
    while (!req_ready && busy < 300) begin
      @(negedge clk);
      busy++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input int cmd, input int addr, input int tag, output int busy);
    clear_logs();
    send(cmd, addr, tag);
    wait_idle(busy);
  endtask

  task automatic expect_ops(input string req, input int n,
                            input int o0, input int a0, input int o1, input int a1,
                            input int o2, input int a2);
    int eo [3];
    int ea [3];
    eo = '{o0, o1, o2};
    ea = '{a0, a1, a2};
    chk(op_cnt == n, req, "link cycle count", op_cnt, n);
    for (int i = 0; i < n && i < op_cnt; i++) begin
      chk(op_log[i] == eo[i], req, "link opcode", op_log[i], eo[i]);
      chk(ad_log[i] == ea[i], req, "link address", ad_log[i], ea[i]);
    end
  endtask

  task automatic expect_rsp(input string req, input int kind, input int tag, input int data);
    chk(rsp_cnt == 1, req, "response count", rsp_cnt, 1);
    chk(rk_log[0] == kind, req, "response kind", rk_log[0], kind);
    chk(rt_log[0] == tag, req, "response tag", rt_log[0], tag);
    chk(rd_log[0] == data, req, "response data flag", rd_log[0], data);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
    chk(link_valid == 1'b0, "R9", "link idle after reset", int'(link_valid), 0);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_write_basic();
    int b;
    run(1, 8'h01, 1, b);               // R3, R11: slot empty after reset
    expect_ops("R3", 1, 1, 8'h01, 0, 0, 0, 0);
    expect_rsp("R1", 1, 1, 0);
    run(1, 8'h01, 2, b);               // R2: hit modified
    expect_ops("R2", 0, 0, 0, 0, 0, 0, 0);
    expect_rsp("R2", 1, 2, 0);
    run(0, 8'h01, 3, b);               // R4: write-invalidate tail
    expect_ops("R4", 1, 2, 8'h01, 0, 0, 0, 0);
    expect_rsp("R4", 1, 3, 0);
    chk(rsp_t[0] < done_t, "R4", "response before trailing writeback", int'(rsp_t[0]), int'(done_t));
  endtask

  task automatic t_reads();
    int b;
    run(4, 8'h01, 4, b);               // R4/R7: line invalid, one-time fetch
    expect_ops("R7", 1, 6, 8'h01, 0, 0, 0, 0);
    expect_rsp("R1", 2, 4, 1);
    run(3, 8'h01, 5, b);               // R7: shared fetch installs S
    expect_ops("R7", 1, 5, 8'h01, 0, 0, 0, 0);
    expect_rsp("R7", 2, 5, 1);
    run(4, 8'h01, 6, b);               // R6: hit shared
    expect_ops("R6", 0, 0, 0, 0, 0, 0, 0);
    expect_rsp("R6", 2, 6, 1);
    run(3, 8'h01, 7, b);               // R6: state unchanged, still a hit
    expect_ops("R6", 0, 0, 0, 0, 0, 0, 0);
    run(4, 8'h02, 8, b);               // R7: not cached
    expect_ops("R7", 1, 6, 8'h02, 0, 0, 0, 0);
    run(4, 8'h02, 9, b);
    expect_ops("R7", 1, 6, 8'h02, 0, 0, 0, 0);
  endtask

  task automatic t_push();
    int b;
    run(2, 8'h01, 10, b);              // R3 from shared, R4 push tail
    expect_ops("R4", 2, 1, 8'h01, 3, 8'h01, 0, 0);
    expect_rsp("R4", 1, 10, 0);
    run(4, 8'h01, 11, b);              // R4: line now invalid
    expect_ops("R4", 1, 6, 8'h01, 0, 0, 0, 0);
  endtask

  task automatic t_conflict();
    int b;
    run(1, 8'h03, 12, b);
    expect_ops("R11", 1, 1, 8'h03, 0, 0, 0, 0);
    run(3, 8'h0B, 13, b);              // R5: modified victim, same slot
    expect_ops("R5", 2, 2, 8'h03, 5, 8'h0B, 0, 0);
    expect_rsp("R5", 2, 13, 1);
    run(0, 8'h13, 14, b);              // R5: shared victim, then three phases
    expect_ops("R5", 3, 4, 8'h0B, 1, 8'h13, 2, 8'h13);
    expect_rsp("R5", 1, 14, 0);
    chk(b >= 12, "R10", "ready low through all phases", b, 12);
    chk(overlap == 0, "R10", "ready high during link offer", overlap, 0);
  endtask

  task automatic t_fence();
    int b;
    run(1, 8'h05, 0, b);
    clear_logs();
    send(2, 8'h05, 1);                 // R8: push tail pending
    send(5, 8'h0D, 2);
    wait_idle(b);
    expect_ops("R8", 1, 3, 8'h05, 0, 0, 0, 0);
    chk(rsp_cnt == 2, "R8", "response count", rsp_cnt, 2);
    chk(rk_log[0] == 1 && rt_log[0] == 1, "R8", "first response write", rk_log[0], 1);
    chk(rk_log[1] == 3 && rt_log[1] == 2, "R8", "second response fence", rk_log[1], 3);
    chk(rd_log[1] == 0, "R1", "fence carries no data", rd_log[1], 0);
    chk(rsp_t[1] > done_t, "R8", "fence after trailing writeback", int'(rsp_t[1]), int'(done_t));
    run(1, 8'h06, 3, b);
    run(5, 8'h0E, 4, b);               // R8: fence to a conflicting address
    expect_ops("R8", 0, 0, 0, 0, 0, 0, 0);
    expect_rsp("R8", 3, 4, 0);
    run(1, 8'h06, 5, b);               // R8: line untouched, still modified
    expect_ops("R8", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_stall_hold();
    int b;
    clear_logs();
    send(3, 8'h27, 6);                 // R9: offered cycle held during stall
    @(negedge clk);
    while (!link_valid) @(negedge clk);
    @(negedge clk);
    chk(link_valid == 1'b1 && link_op == 3'd5, "R9", "held opcode", int'(link_op), 5);
    wait_idle(b);
    chk(rsp_t[0] > done_t, "R9", "response after completion", int'(rsp_t[0]), int'(done_t));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_basic();
    t_reads();
    t_push();
    t_conflict();
    t_fence();
    t_stall_hold();
    report();
  end

endmodule